// File: doc/BRIEF.md
# Window Watchdog Timer

This block guards a processor against runaway or stalled software. A 6-bit down counter is stepped by a prescaled tick. Software must refresh it by writing a 32-bit key, and only inside a window. That window is open while the counter is at or below a programmable compare value. A refresh that comes too early asks for a system reset. A counter that reaches zero and then takes one more tick does the same. When the counter falls to the compare value, an interrupt flag is raised as an early warning.

Software reaches the block through four word registers on a plain write strobe and word-index port, with a combinational read path. The outputs are an interrupt level and a single-cycle reset request. The block has two resets. The normal synchronous reset clears the counter and its control. A separate power-on reset clears only the flag that records a watchdog reset, so the flag survives the reset the watchdog itself requested. A debug-acknowledge input can freeze counting.

Top module: `win_wdog`

## Requirements
- R1: Word index 1 holds the control settings: bit 0 run enable, bit 1 interrupt enable, bits 11:8 tick-rate code, bits 21:16 window compare value, bit 31 debug-freeze disable. All other bits read 0. Word index 0 always reads 0. Control resets to 0.
- R2: Word index 3 reads the live counter in bits 5:0 with zeros above it. The counter resets to 63.
- R3: While running, the counter drops by one every N clocks, where rate codes 0..15 give N = 1, 2, 4, 8, 16, 32, 64, 128, 192, 256, 384, 512, 768, 1024, 1536, 2048. With run enable at 0 the counter holds.
- R4: A write of 0x00005AA5 to word index 0 while the counter is at or below the compare value reloads it to 63 on the next edge and restarts the tick period. Any other value written there changes nothing.
- R5: A key write while the counter is above the compare value raises the reset request on the next edge and does not reload the counter.
- R6: A tick that arrives while the counter is 0, with no valid refresh in the same cycle, raises the reset request and reloads the counter to 63.
- R7: Status bit 0 (word index 2) is set when a tick brings the counter down to the compare value. Writing 1 to it clears it, and a set in the same cycle wins over the clear.
- R8: The interrupt output is high exactly while status bit 0 and the interrupt enable are both 1.
- R9: Status bit 1 is set with every reset request. Writing 1 to it clears it. The normal reset leaves it alone, and only the power-on reset clears it.
- R10: With debug-freeze disable at 0, a high debug-acknowledge stops counting. With it at 1, counting goes on.
- R11: A control write that changes the rate code restarts the tick period from zero.
- R12: The reset request is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset for counter, control and interrupt flag |
| por_n | input | 1 | Synchronous active-low power-on reset for the reset-occurred flag |
| dbg_ack | input | 1 | Debug halt acknowledge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word index (0 refresh, 1 control, 2 status, 3 counter) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr |
| irq | output | 1 | Compare-match interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong tick period or a prescaler that is not cleared moves the counter readout by one step. That is visible on the counter word within one divisor period of the fault. A wrong window decision shows on the next edge, either as a reset pulse where none is due or as a missing reload to 63. A lost or stuck interrupt flag shows on the interrupt line and the status word in the cycle after the counter reaches the compare value. The reset-occurred flag must come through a normal reset unchanged.

// File: rtl/wdog_pkg.sv
// Shared constants, register types and tick-rate decode for the window watchdog.
// Assumes a 6-bit counter and a 12-bit prescaler, wide enough for a 2048 divisor.
package wdog_pkg;
    localparam int          CNT_W   = 6;
    localparam int          PSC_W   = 12;
    localparam logic [31:0] KEY_VAL = 32'h0000_5AA5;

    typedef enum logic [1:0] {
        IDX_REFRESH = 2'd0,
        IDX_CTRL    = 2'd1,
        IDX_STAT    = 2'd2,
        IDX_COUNT   = 2'd3
    } word_idx_e;

    typedef struct packed {
        logic             frz_dis;
        logic [CNT_W-1:0] win;
        logic [3:0]       rate;
        logic             ie;
        logic             run_en;
    } ctrl_t;

    // Divisor for a rate code: powers of two up to 128, then alternating 3*2^k and 2^k.
    function automatic logic [PSC_W-1:0] rate_div(input logic [3:0] code);
        logic [PSC_W-1:0] d;
        if (!code[3])
            d = PSC_W'(1) << code[2:0];
        else if (!code[0])
            d = PSC_W'(3) << (4'(code[2:1]) + 4'd6);
        else
            d = PSC_W'(1) << (4'(code[2:1]) + 4'd8);
        return d;
    endfunction
endpackage

// File: rtl/wdog_prescale.sv
// Tick generator: counts clocks while running and emits one tick per divisor period.
// Assumes clr is raised on every counter reload and on every change of the rate code.
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter int PW = PSC_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] rate,
    input  logic       clr,
    output logic       tick
);
    logic [PW-1:0] div;
    logic [PW-1:0] acc_q;

    assign div  = PW'(rate_div(rate));
    // A tick ends the period; >= keeps a stale count from running away.
    assign tick = run && (acc_q >= div - PW'(1));

    // Period accumulator: restarts on clear or tick, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr || tick)
            acc_q <= '0;
        else if (run)
            acc_q <= acc_q + PW'(1);
    end
endmodule

// File: rtl/wdog_counter.sv
// Window down counter: makes the refresh window decision and detects timeout.
// Assumes key_wr is already qualified by reset and address; reload wins over a tick.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          key_wr,
    input  logic [CW-1:0] win,
    output logic [CW-1:0] cnt,
    output logic          match,
    output logic          fire,
    output logic          reload
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic          in_win_key;
    logic          early_key;
    logic          expire;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_dec;

    assign cnt_dec    = cnt_q - CW'(1);
    assign in_win_key = key_wr && (cnt_q <= win);
    assign early_key  = key_wr && (cnt_q > win);
    assign expire     = tick && (cnt_q == '0) && !in_win_key;
    assign reload     = in_win_key || expire;
    assign fire       = early_key || expire;
    assign match      = tick && !in_win_key && (cnt_q != '0) && (cnt_dec == win);
    assign cnt        = cnt_q;

    // Counter state: reload to the top, otherwise step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= TOP;
        else if (reload)
            cnt_q <= TOP;
        else if (tick)
            cnt_q <= cnt_dec;
    end
endmodule

// File: rtl/wdog_regs.sv
// Register file: control word, interrupt flag, reset-occurred flag and read mux.
// Assumes the reset-occurred flag lives on por_n so that rst_n leaves it intact.
module wdog_regs
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  ctrl_t            ctrl_wd,
    input  logic [1:0]       stat_w1c,
    input  logic [CNT_W-1:0] cnt,
    input  logic             match,
    input  logic             fire,
    output ctrl_t            ctrl,
    output logic             rate_chg,
    output logic             irq_flag,
    output logic             rst_flag,
    output logic [31:0]      rdata
);
    logic  ctrl_wr;
    logic  stat_wr;
    ctrl_t ctrl_q;

    assign ctrl_wr  = wr_en && (addr == IDX_CTRL);
    assign stat_wr  = wr_en && (addr == IDX_STAT);
    assign rate_chg = ctrl_wr && (ctrl_wd.rate != ctrl_q.rate);
    assign ctrl     = ctrl_q;

    // Control word: loaded by a write to its index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_wd;
    end

    // Compare-match flag: set by a match, cleared by writing 1, set first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (match)
            irq_flag <= 1'b1;
        else if (stat_wr && stat_w1c[0])
            irq_flag <= 1'b0;
    end

    // Reset-occurred flag: power-on domain, set by a reset request, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!por_n)
            rst_flag <= 1'b0;
        else if (fire)
            rst_flag <= 1'b1;
        else if (rst_n && stat_wr && stat_w1c[1])
            rst_flag <= 1'b0;
    end

    // Read mux: assembles the word selected by addr.
    always_comb begin
        unique case (addr)
            IDX_CTRL:  rdata = {ctrl_q.frz_dis, 9'b0, ctrl_q.win, 4'b0, ctrl_q.rate,
                                6'b0, ctrl_q.ie, ctrl_q.run_en};
            IDX_STAT:  rdata = {30'b0, rst_flag, irq_flag};
            IDX_COUNT: rdata = {{(32-CNT_W){1'b0}}, cnt};
            default:   rdata = 32'b0;
        endcase
    end
endmodule

// File: rtl/win_wdog.sv
// Window watchdog top: decodes the refresh key, gates counting, drives the outputs.
// Assumes one register write per cycle and a clean synchronous rst_n and por_n.
module win_wdog
    import wdog_pkg::*;
#(
    parameter logic [31:0] REFRESH_KEY = KEY_VAL,
    parameter int          PSC_BITS    = PSC_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        dbg_ack,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        rst_req
);
    ctrl_t            ctrl;
    ctrl_t            ctrl_wd;
    logic             rate_chg;
    logic             irq_flag;
    logic             rst_flag;
    logic             key_wr;
    logic             run;
    logic             tick;
    logic             match;
    logic             fire_raw;
    logic             fire;
    logic             reload;
    logic [CNT_W-1:0] cnt;

    assign ctrl_wd = '{frz_dis: wdata[31], win: wdata[16 +: CNT_W], rate: wdata[11:8],
                       ie: wdata[1], run_en: wdata[0]};
    assign key_wr  = rst_n && wr_en && (addr == IDX_REFRESH) && (wdata == REFRESH_KEY);
    assign run     = ctrl.run_en && !(dbg_ack && !ctrl.frz_dis);
    assign fire    = rst_n && fire_raw;
    assign irq     = irq_flag && ctrl.ie;

    wdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .addr(addr),
        .ctrl_wd(ctrl_wd), .stat_w1c(wdata[1:0]), .cnt(cnt), .match(match),
        .fire(fire), .ctrl(ctrl), .rate_chg(rate_chg), .irq_flag(irq_flag),
        .rst_flag(rst_flag), .rdata(rdata)
    );

    wdog_prescale #(.PW(PSC_BITS)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .rate(ctrl.rate),
        .clr(reload || rate_chg), .tick(tick)
    );

    wdog_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .key_wr(key_wr), .win(ctrl.win),
        .cnt(cnt), .match(match), .fire(fire_raw), .reload(reload)
    );

    // Reset request: one cycle per event, never two cycles back to back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= fire && !rst_req;
    end
endmodule

// File: rtl/wdog_chk.sv
// Property checker for the window watchdog, bound onto every win_wdog instance.
// Assumes it observes the top's internal decode through the bind connections.
module wdog_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             key_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] win,
    input logic             tick,
    input logic             match,
    input logic             irq_flag,
    input logic             rst_flag,
    input logic             rst_req,
    input logic             dbg_ack,
    input logic             frz_dis
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                                 // R12
    AST_KEY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && cnt <= win) |=> (cnt == TOP));                              // R4
    AST_EARLY_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && cnt > win && !rst_req) |=> rst_req);                        // R5
    AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !key_wr && !rst_req) |=> (rst_req && cnt == TOP)); // R6
    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_flag);                                                   // R7
    AST_IDLE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !key_wr) |=> $stable(cnt));                                  // R3
    AST_FLAG_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rst_req && $past(por_n)) |-> rst_flag);                               // R9
    AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ack && !frz_dis) |-> !tick);                                      // R10
endmodule

bind win_wdog wdog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .key_wr(key_wr), .cnt(cnt),
    .win(ctrl.win), .tick(tick), .match(match), .irq_flag(irq_flag),
    .rst_flag(rst_flag), .rst_req(rst_req), .dbg_ack(dbg_ack), .frz_dis(ctrl.frz_dis)
);

// File: tb/win_wdog_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module win_wdog_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] KEY        = 32'h0000_5AA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        dbg_ack = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd3;
    logic [31:0] wdata = 32'b0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_en, m_ie, m_sel, m_cmp, m_dd, m_cnt, m_psc, m_if, m_rf, m_rq;

    win_wdog u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .dbg_ack(dbg_ack), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int divof(input int s);
        case (s)
            0: return 1;     1: return 2;     2: return 4;     3: return 8;
            4: return 16;    5: return 32;    6: return 64;    7: return 128;
            8: return 192;   9: return 256;   10: return 384;  11: return 512;
            12: return 768;  13: return 1024; 14: return 1536; default: return 2048;
        endcase
    endfunction

    function automatic logic [31:0] mread(input logic [1:0] a);
        case (a)
            2'd1: return (32'(m_dd) << 31) | (32'(m_cmp) << 16) | (32'(m_sel) << 8)
                         | (32'(m_ie) << 1) | 32'(m_en);
            2'd2: return (32'(m_rf) << 1) | 32'(m_if);
            2'd3: return 32'(m_cnt);
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances on each rising edge from the inputs driven at negedge.
    always @(posedge clk) begin
        int  dv;
        bit  run, tk, key, valid, early, tout, fire, match, ctw, stw, selchg;
        dv     = divof(m_sel);
        run    = (m_en != 0) && !(dbg_ack && m_dd == 0);
        tk     = run && (m_psc == dv - 1);
        key    = rst_n && wr_en && addr == 2'd0 && wdata == KEY;
        valid  = key && (m_cnt <= m_cmp);
        early  = key && !valid;
        tout   = tk && m_cnt == 0 && !valid;
        fire   = rst_n && (early || tout);
        match  = tk && !valid && m_cnt != 0 && (m_cnt - 1) == m_cmp;
        ctw    = wr_en && addr == 2'd1;
        stw    = wr_en && addr == 2'd2;
        selchg = ctw && (int'(wdata[11:8]) != m_sel);
        if (!por_n) m_rf = 0;
        else if (fire) m_rf = 1;
        else if (rst_n && stw && wdata[1]) m_rf = 0;
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_sel = 0; m_cmp = 0; m_dd = 0;
            m_cnt = 63; m_psc = 0; m_if = 0; m_rq = 0;
        end else begin
            if (match) m_if = 1;
            else if (stw && wdata[0]) m_if = 0;
            m_rq = (fire && m_rq == 0) ? 1 : 0;
            if (valid || tout) m_cnt = 63;
            else if (tk) m_cnt = m_cnt - 1;
            if (valid || tout || selchg || tk) m_psc = 0;
            else if (run) m_psc = m_psc + 1;
            if (ctw) begin
                m_en = int'(wdata[0]); m_ie = int'(wdata[1]); m_sel = int'(wdata[11:8]);
                m_cmp = int'(wdata[21:16]); m_dd = int'(wdata[31]);
            end
        end
        live = 1'b1;
    end

    // Every-clock comparison, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (live && !done) begin
            chk(32'(irq), 32'(m_if & m_ie), "R8 irq line");
            chk(32'(rst_req), 32'(m_rq), "R5/R6 reset request");
            case (addr)
                2'd1: chk(rdata, mread(addr), "R1 control word");
                2'd2: chk(rdata, mread(addr), "R7 status word");
                2'd3: chk(rdata, mread(addr), "R2 counter word");
                default: chk(rdata, mread(addr), "R1 refresh word");
            endcase
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'b0; addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        idle(3);
        rst_n = 1'b1; por_n = 1'b1;
        idle(1);
        rd(2'd3, 32'd63, "R2 counter after reset");
        rd(2'd1, 32'h0, "R1 control after reset");
        rd(2'd0, 32'h0, "R1 refresh word reads zero");
        rd(2'd2, 32'h0, "R9 status after reset");
        // run at divide-by-4, window 48
        wr(2'd1, 32'h0030_0203);
        rd(2'd1, 32'h0030_0203, "R1 control readback");
        idle(40);
        rd(2'd3, 32'd53, "R3 ten ticks at divide-by-4");
        // refresh before the window opens
        wr(2'd0, KEY);
        #1 chk(32'(rst_req), 32'd1, "R5 early refresh raises reset");
        idle(1);
        #1 chk(32'(rst_req), 32'd0, "R12 reset request lasts one cycle");
        rd(2'd2, 32'h2, "R9 reset flag set");
        wr(2'd2, 32'h2);
        rd(2'd2, 32'h0, "R9 reset flag write-one clear");
        // stop counting, then refresh with a wrong and a right key
        wr(2'd1, 32'h003F_0202);
        addr = 2'd3; #1 held = rdata;
        idle(5);
        rd(2'd3, held, "R3 disabled counter holds");
        wr(2'd0, 32'h0000_5AA4);
        rd(2'd3, held, "R4 wrong key ignored");
        chk(32'(rst_req), 32'd0, "R4 wrong key raises no reset");
        wr(2'd0, KEY);
        rd(2'd3, 32'd63, "R4 key reloads counter");
        // compare match at 60, divide-by-1
        wr(2'd1, 32'h003C_0003);
        idle(2);
        rd(2'd2, 32'h0, "R7 flag clear before match");
        idle(1);
        rd(2'd2, 32'h1, "R7 flag set on match");
        #1 chk(32'(irq), 32'd1, "R8 irq with enable");
        wr(2'd1, 32'h003C_0001);
        #1 chk(32'(irq), 32'd0, "R8 irq masked");
        rd(2'd2, 32'h1, "R7 flag kept when masked");
        wr(2'd2, 32'h1);
        rd(2'd2, 32'h0, "R7 flag write-one clear");
        // timeout
        wr(2'd0, KEY);
        idle(63);
        rd(2'd3, 32'd0, "R6 counter reaches zero");
        #1 chk(32'(rst_req), 32'd0, "R6 no reset before timeout tick");
        idle(1);
        #1 chk(32'(rst_req), 32'd1, "R6 timeout raises reset");
        rd(2'd3, 32'd63, "R6 counter reloads after timeout");
        // reset flag survives normal reset, cleared by power-on reset
        idle(1);
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        rd(2'd2, 32'h2, "R9 flag survives normal reset");
        por_n = 1'b0; idle(1); por_n = 1'b1; idle(1);
        rd(2'd2, 32'h0, "R9 flag cleared by power-on reset");
        // debug freeze
        wr(2'd1, 32'h003F_0001);
        dbg_ack = 1'b1;
        idle(20);
        rd(2'd3, 32'd63, "R10 debug acknowledge freezes");
        wr(2'd1, 32'h803F_0001);
        idle(10);
        rd(2'd3, 32'd53, "R10 freeze disable keeps counting");
        dbg_ack = 1'b0;
        // rate change restarts the period
        wr(2'd1, 32'h003F_0501);
        wr(2'd0, KEY);
        idle(19);
        wr(2'd1, 32'h003F_0401);
        idle(15);
        rd(2'd3, 32'd63, "R11 period restarted on rate change");
        idle(1);
        rd(2'd3, 32'd62, "R11 first tick after full period");
        // non-power-of-two and largest divisors
        wr(2'd1, 32'h003F_0801);
        wr(2'd0, KEY);
        idle(191);
        rd(2'd3, 32'd63, "R3 divide-by-192 before tick");
        idle(1);
        rd(2'd3, 32'd62, "R3 divide-by-192 tick");
        wr(2'd1, 32'h003F_0F01);
        wr(2'd0, KEY);
        idle(2047);
        rd(2'd3, 32'd63, "R3 divide-by-2048 before tick");
        idle(1);
        rd(2'd3, 32'd62, "R3 divide-by-2048 tick");
        idle(5);
        finish_run();
    end
endmodule